// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port to an external asynchronous static RAM of 64K 16-bit words. The RAM has one shared data bus, active-low chip select, output enable and write strobe, and one active-low enable for each byte lane. A requester issues one read or one write at a time through a valid/ready handshake. Each request carries an address, write data and a byte mask. Read results come back on a response port, marked by a strobe that lasts one cycle.

Every RAM timing limit is a parameter in nanoseconds, and the clock period is one too. The controller rounds each limit up to whole clock cycles and holds the strobes for that count. The pad drivers sit outside the block. The controller drives the data bus only while the write strobe is low. Whenever a write follows a read, it inserts a bus-turnaround gap so that the RAM and the controller never drive the bus together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is active, chip select, output enable, write strobe and both lane enables are high. The data drivers are off, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A read holds chip select and output enable low and the write strobe high for RD_CYC = ceil(max(cycle, address access, output-enable access)/clock) cycles (2 by default). `rsp_valid_o` goes high for exactly one cycle, in the cycle after the last read cycle.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, lane enable index 0). Mask bit 1 selects the upper lane (bits 15:8, index 1). A selected lane's enable is low during the access. In the read response, lanes that were not selected are returned as zero.
- R4: A write holds chip select and the write strobe low and output enable high for WR_CYC = ceil(max(cycle, pulse width, data setup)/clock) cycles (2 by default). The data drivers are on only in those cycles. Only the selected lanes are stored.
- R5: A mask of 00 still runs a full access with both lane enables high. The RAM contents do not change, and a read returns 0 with its normal strobe.
- R6: A write that follows a read sees, after the accepting cycle, TURN_CYC = ceil(output turn-off/clock) extra cycles with the strobes high (1 by default). Output enable and the write strobe are never low together.
- R7: `req_ready_o` falls in the cycle after a request is accepted. It stays low until the access ends, so only one access is in flight.
- R8: The full 16-bit request address appears on `mem_addr_o` and stays stable while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, able to accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane select mask, bit 0 lower byte |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| mem_addr_o | output | 16 | RAM address |
| mem_ce_n_o | output | 1 | RAM chip select, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_be_n_o | output | 2 | RAM lane enables, active low, index 0 lower |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Pad driver enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the RAM bus |

## Verification
The bench counts falling clock edges from the rising edge that accepts a request, and samples at each one.
- The read strobe is due at the third falling edge (RD_CYC+1), and output enable must be low at exactly two.
- After a write, the write strobe must first be low at the first falling edge. After a read, it is first low at the second (TURN_CYC+1), and it stays low for two.
- `req_ready_o` must be low at the first falling edge and at every one where chip select is low.

All of these counts come from the nanosecond values through the bench's own round-up arithmetic. The bench then reads the stored words back, and compares them against a shadow copy that applies the lane masks.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_dec.sv
module sram_lane_dec #(
  parameter int LANES = 2
) (
  input  logic               act_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [LANES*8-1:0] raw_i,
  output logic [LANES-1:0]   be_n_o,
  output logic [LANES*8-1:0] masked_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n_o[l]           = !(act_i && be_i[l]);
    assign masked_o[l*8 +: 8]  = be_i[l] ? raw_i[l*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic accept_o,
  output logic cap_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic dq_oe_o
);

  seq_st_e          st_q, st_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             tmr_zero;
  logic             last_rd_q;

  sram_cyc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    cap_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        load = 1'b1;
        if (!req_we_i) begin
          st_d     = ST_RD;
          load_val = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          st_d     = ST_TURN;
          load_val = CNT_W'(TURN_CYC - 1);
        end else begin
          st_d     = ST_WR;
          load_val = CNT_W'(WR_CYC - 1);
        end
      end
      ST_TURN: if (tmr_zero) begin
        st_d     = ST_WR;
        load     = 1'b1;
        load_val = CNT_W'(WR_CYC - 1);
      end
      ST_RD: if (tmr_zero) begin
        st_d  = ST_IDLE;
        cap_o = 1'b1;
      end
      ST_WR: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_o)            last_rd_q <= 1'b1;
      else if (st_q == ST_WR) last_rd_q <= 1'b0;
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;
  assign ce_n_o   = !((st_q == ST_RD) || (st_q == ST_WR));
  assign oe_n_o   = (st_q != ST_RD);
  assign we_n_o   = (st_q != ST_WR);
  assign dq_oe_o  = (st_q == ST_WR);

  // phase length checkers
  logic [7:0] ph_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_len_q <= '0;
    else if (st_d != st_q) ph_len_q <= '0;
    else if (ph_len_q != 8'hFF) ph_len_q <= ph_len_q + 1'b1;
  end

  assert_rd_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && st_d != ST_RD) |-> (ph_len_q == 8'(RD_CYC - 1)));

  assert_wr_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && st_d != ST_WR) |-> (ph_len_q == 8'(WR_CYC - 1)));

  assert_turn_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> $past(oe_n_o));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 15,
  parameter int T_AA_NS   = 15,
  parameter int T_OE_NS   = 7,
  parameter int T_WC_NS   = 15,
  parameter int T_WP_NS   = 10,
  parameter int T_DS_NS   = 7,
  parameter int T_OFF_NS  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W/8-1:0] mem_be_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = int'(ns_to_cyc(max3(T_RC_NS, T_AA_NS, T_OE_NS), CLK_NS));
  localparam int WR_CYC   = int'(ns_to_cyc(max3(T_WC_NS, T_WP_NS, T_DS_NS), CLK_NS));
  localparam int TURN_CYC = int'(ns_to_cyc(T_OFF_NS, CLK_NS));
  localparam int MAX_CYC  = int'(max3(RD_CYC, WR_CYC, TURN_CYC));
  localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic              accept, cap;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, masked;
  logic [LANES-1:0]  be_q;
  logic              rsp_valid_q;

  sram_seq #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .cap_o       (cap),
    .ce_n_o      (mem_ce_n_o),
    .oe_n_o      (mem_oe_n_o),
    .we_n_o      (mem_we_n_o),
    .dq_oe_o     (mem_dq_oe_o)
  );

  sram_lane_dec #(.LANES(LANES)) i_lane (
    .act_i    (!mem_ce_n_o),
    .be_i     (be_q),
    .raw_i    (mem_dq_i),
    .be_n_o   (mem_be_n_o),
    .masked_o (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      if (cap) rdata_q <= masked;
      rsp_valid_q <= cap;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_n_o |-> (mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && (&mem_be_n_o)));

  assert_rsp_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_no_clash_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && (!mem_we_n_o || mem_dq_oe_o)));

  assert_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK_NS = 8;
  localparam int E_RD   = (15 + CLK_NS - 1) / CLK_NS;
  localparam int E_WR   = (15 + CLK_NS - 1) / CLK_NS;
  localparam int E_TURN = (7 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, ce_n, oe_n, we_n, dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0]  be_n;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_be_n_o(be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  // RAM model, 256 words indexed by low address byte
  logic [15:0] ram [0:255];
  logic [15:0] shadow [0:255];

  always @(negedge clk)
    if (!ce_n && !we_n && dq_oe) begin
      if (!be_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!be_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end

  assign mem_dq_i = (!ce_n && we_n && !oe_n) ?
    {(be_n[1] ? 8'hA5 : ram[mem_addr[7:0]][15:8]), (be_n[0] ? 8'h5A : ram[mem_addr[7:0]][7:0])}
    : 16'hDEAD;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-request observations
  int          o_we_first, o_we_cnt, o_oe_cnt, o_rv_at, o_rv_cnt;
  logic [15:0] o_rdata;
  bit          o_busy_ok, o_addr_ok, o_clash, o_drv_ok, o_lane_ok;

  task automatic run_req(input bit we, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
    o_we_first = 0; o_we_cnt = 0; o_oe_cnt = 0; o_rv_at = 0; o_rv_cnt = 0;
    o_rdata = '0; o_busy_ok = 1; o_addr_ok = 1; o_clash = 0; o_drv_ok = 1; o_lane_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 1'b0;
        if (req_ready) o_busy_ok = 0;
      end
      if (!ce_n && req_ready) o_busy_ok = 0;
      if (!ce_n && mem_addr != a) o_addr_ok = 0;
      if (!ce_n && be_n != ~be) o_lane_ok = 0;
      if (ce_n && be_n != 2'b11) o_lane_ok = 0;
      if (!we_n) begin
        o_we_cnt++;
        if (o_we_first == 0) o_we_first = i;
      end
      if (!oe_n) o_oe_cnt++;
      if (!oe_n && (!we_n || dq_oe)) o_clash = 1;
      if (dq_oe != !we_n) o_drv_ok = 0;
      if (rsp_valid) begin
        o_rv_cnt++;
        if (o_rv_at == 0) begin o_rv_at = i; o_rdata = rsp_rdata; end
      end
    end
    if (we) begin
      if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [15:0] v, input logic [1:0] be);
    return {(be[1] ? v[15:8] : 8'h00), (be[0] ? v[7:0] : 8'h00)};
  endfunction

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    chk({ce_n, oe_n, we_n} == 3'b111, "R1 strobes", 32'({ce_n, oe_n, we_n}), 7);
    chk(be_n == 2'b11 && !dq_oe, "R1 lanes/drv", 32'({be_n, dq_oe}), 32'h6);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_word;
    run_req(1'b1, 16'h0010, 16'h1234, 2'b11);
    chk(o_we_first == 1, "R4 write start", o_we_first, 1);
    chk(o_we_cnt == E_WR, "R4 write length", o_we_cnt, E_WR);
    chk(o_oe_cnt == 0 && o_drv_ok, "R4 oe high, drive only in pulse", o_oe_cnt, 0);
    chk(o_busy_ok, "R7 ready low while busy (wr)", 32'(o_busy_ok), 1);
    run_req(1'b0, 16'h0010, 16'h0000, 2'b11);
    chk(o_oe_cnt == E_RD, "R2 read length", o_oe_cnt, E_RD);
    chk(o_we_cnt == 0, "R2 we high in read", o_we_cnt, 0);
    chk(o_rv_at == E_RD + 1 && o_rv_cnt == 1, "R2 response timing", o_rv_at, E_RD + 1);
    chk(o_rdata == shadow[8'h10], "R2 word data", o_rdata, shadow[8'h10]);
    chk(o_busy_ok, "R7 ready low while busy (rd)", 32'(o_busy_ok), 1);
  endtask

  task automatic t_lanes;
    run_req(1'b1, 16'h0011, 16'hAABB, 2'b11);
    run_req(1'b1, 16'h0011, 16'h1122, 2'b01);
    chk(o_lane_ok, "R3 lane enables on lower write", 32'(be_n), 32'h2);
    run_req(1'b0, 16'h0011, 16'h0, 2'b11);
    chk(o_rdata == shadow[8'h11], "R4 partial write kept upper", o_rdata, shadow[8'h11]);
    chk(o_rdata == 16'hAA22, "R4 merged word", o_rdata, 16'hAA22);
    run_req(1'b0, 16'h0011, 16'h0, 2'b10);
    chk(o_rdata == lane_mask(shadow[8'h11], 2'b10), "R3 upper-only read", o_rdata,
        lane_mask(shadow[8'h11], 2'b10));
    chk(o_lane_ok, "R3 upper lane enable", 32'(o_lane_ok), 1);
    run_req(1'b0, 16'h0011, 16'h0, 2'b01);
    chk(o_rdata == lane_mask(shadow[8'h11], 2'b01), "R3 lower-only read", o_rdata,
        lane_mask(shadow[8'h11], 2'b01));
  endtask

  task automatic t_empty;
    run_req(1'b1, 16'h0011, 16'hFFFF, 2'b00);
    chk(o_lane_ok && o_we_cnt == E_WR, "R5 empty write runs, lanes off", o_we_cnt, E_WR);
    run_req(1'b0, 16'h0011, 16'h0, 2'b11);
    chk(o_rdata == 16'hAA22, "R5 empty write left data", o_rdata, 16'hAA22);
    run_req(1'b0, 16'h0011, 16'h0, 2'b00);
    chk(o_rv_cnt == 1 && o_rdata == 16'h0000, "R5 empty read returns zero", o_rdata, 0);
    chk(o_lane_ok, "R5 lanes high on empty read", 32'(o_lane_ok), 1);
  endtask

  task automatic t_turn;
    run_req(1'b0, 16'h0010, 16'h0, 2'b11);
    run_req(1'b1, 16'h0012, 16'h5566, 2'b11);
    chk(o_we_first == E_TURN + 1, "R6 turnaround after read", o_we_first, E_TURN + 1);
    chk(!o_clash, "R6 no bus clash", 32'(o_clash), 0);
    run_req(1'b1, 16'h0013, 16'h7788, 2'b11);
    chk(o_we_first == 1, "R6 no gap write after write", o_we_first, 1);
    run_req(1'b0, 16'h0012, 16'h0, 2'b11);
    chk(o_rdata == 16'h5566, "R6 write after read stored", o_rdata, 16'h5566);
  endtask

  task automatic t_addr;
    run_req(1'b1, 16'hFF03, 16'hC0DE, 2'b11);
    chk(o_addr_ok, "R8 high address on write", 32'(mem_addr), 32'hFF03);
    run_req(1'b0, 16'hFF03, 16'h0, 2'b11);
    chk(o_addr_ok && o_rdata == 16'hC0DE, "R8 high address read", o_rdata, 16'hC0DE);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_word();
    t_lanes();
    t_empty();
    t_turn();
    t_addr();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule